// File: doc/BRIEF.md
# Multi-Context Reservation Monitor

This block decides the outcome of load-linked / store-conditional pairs for a set of hardware thread contexts that share one memory. Each context owns one reservation, which is a valid bit plus the address it last load-linked. Requests arrive on `NLANE` parallel request lanes. Each lane carries a kind, a context number, a physical address and an uncacheable attribute.

For every store-conditional the monitor returns a result code. It also raises a write enable that tells the memory whether the store may go ahead. Any store that really writes drops every reservation on the same 16-byte block, in all contexts. The monitor never holds data, and it does no translation and no coherence.

Each context counts its consecutive store-conditional failures in a saturating counter. Every `WARN_PERIOD` failures it emits a one-cycle warning tagged with the context, which flags a likely livelock. Results appear one cycle after a request is accepted. `NCTX` must be a power of two.

Top module: `rsv_monitor`

## Requirements
- R1: While reset is asserted, `req_ready` is 0 and no response or warning is issued. Reset leaves every reservation invalid and every failure count at zero. `req_ready` is 1 from the first clock edge after reset is released.
- R2: A load-linked request (kind 0) makes the issuing context's reservation valid and records the request address. Its response has code 1 and write enable 0.
- R3: A cacheable store-conditional (kind 1, uncacheable 0) passes only when the issuer's reservation is valid and its address equals the request address with address bits [3:0] ignored. A pass returns code 1 with write enable 1.
- R4: A cacheable store-conditional that does not pass returns code 0 with write enable 0. It invalidates the issuer's own reservation and adds one to that context's failure count.
- R5: An uncacheable store-conditional returns code 2 with write enable 1 and skips the reservation test. It resets the issuer's failure count to zero and invalidates matching reservations in the same way a plain store does.
- R6: A plain store (kind 2) returns code 3 with write enable 1. A plain store or a passing store-conditional invalidates every context whose recorded address lies in the same 16-byte block, the issuer included.
- R7: A failing store-conditional leaves the reservations of all other contexts unchanged.
- R8: When a failure brings a context's count to a nonzero multiple of `WARN_PERIOD`, `warn_valid` of that lane is high for one cycle, together with the failing response, and `warn_ctx` carries the context.
- R9: The failure count saturates at its all-ones value. Failures at saturation produce no further warnings. A passing store-conditional resets the count to zero.
- R10: The response (`rsp_valid`, `rsp_code`, `wr_en`) for a request accepted at one clock edge is presented from that edge until the next edge, and at no other time.
- R11: Requests accepted in the same cycle are applied in a fixed order. First come all stores and store-conditionals, in ascending lane order, each seeing the effects of earlier lanes. Then come all load-linked requests, in ascending lane order.
- R12: Kind 3 is ignored. It gives no response and leaves every reservation and count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NLANE | Per-lane request valid |
| req_ready | output | 1 | Requests accepted when high (all lanes) |
| req_kind | input | 2*NLANE | Per-lane kind: 0 load-linked, 1 store-conditional, 2 store, 3 ignored |
| req_ctx | input | CTX_W*NLANE | Per-lane issuing context |
| req_addr | input | ADDR_W*NLANE | Per-lane physical address |
| req_uncached | input | NLANE | Per-lane uncacheable attribute |
| rsp_valid | output | NLANE | Per-lane response valid |
| rsp_code | output | 2*NLANE | Per-lane result: 0 fail, 1 pass or load-linked, 2 uncacheable, 3 store |
| wr_en | output | NLANE | Per-lane permission for the memory write |
| warn_valid | output | NLANE | Per-lane failure-streak warning pulse |
| warn_ctx | output | CTX_W*NLANE | Context named by the warning |

## Verification
Two lanes can fall in the same cycle: a store that invalidates a block and a load-linked to that block, or two store-conditionals that compete for one block. The bench provokes both by driving both lanes in one cycle. In the first case a load-linked on lane 0 meets a store from another context on lane 1, and a later store-conditional must still pass, because the store is applied first. In the second case two contexts issue store-conditionals to one block, and only the lower lane may pass. A scoreboard model, which applies the same ordering rules, predicts each lane's code, write enable and warning, and a monitor compares them one cycle later.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        KIND_LL  = 2'd0,
        KIND_SC  = 2'd1,
        KIND_ST  = 2'd2,
        KIND_NOP = 2'd3
    } rsv_kind_e;

    typedef enum logic [1:0] {
        CODE_FAIL = 2'd0,
        CODE_PASS = 2'd1,
        CODE_UNC  = 2'd2,
        CODE_WR   = 2'd3
    } rsv_code_e;

endpackage

// File: rtl/rsv_lane_unpack.sv
module rsv_lane_unpack
    import rsv_pkg::*;
#(
    parameter int CTX_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              valid_i,
    input  logic              ready_i,
    input  logic [1:0]        kind_i,
    input  logic [CTX_W-1:0]  ctx_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              unc_i,
    output logic              is_ll_o,
    output logic              is_sc_o,
    output logic              is_st_o,
    output logic              unc_o,
    output logic [CTX_W-1:0]  ctx_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic take;

    always_comb begin
        take    = valid_i && ready_i;
        is_ll_o = take && (kind_i == KIND_LL);
        is_sc_o = take && (kind_i == KIND_SC);
        is_st_o = take && (kind_i == KIND_ST);
        unc_o   = unc_i;
        ctx_o   = ctx_i;
        addr_o  = addr_i;
    end
endmodule

// File: rtl/rsv_blk_cmp.sv
module rsv_blk_cmp #(
    parameter int ADDR_W  = 32,
    parameter int BLK_LSB = 4
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    output logic              same_o
);
    // Only the bits above the block offset take part in the match.
    assign same_o = (a_i[ADDR_W-1:BLK_LSB] == b_i[ADDR_W-1:BLK_LSB]);
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
    import rsv_pkg::*;
#(
    parameter  int NLANE       = 2,
    parameter  int NCTX        = 4,
    parameter  int ADDR_W      = 32,
    parameter  int BLK_LSB     = 4,
    parameter  int FAIL_W      = 20,
    parameter  int WARN_PERIOD = 100000,
    localparam int CTX_W       = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NLANE-1:0]          req_valid,
    output logic                      req_ready,
    input  logic [2*NLANE-1:0]        req_kind,
    input  logic [CTX_W*NLANE-1:0]    req_ctx,
    input  logic [ADDR_W*NLANE-1:0]   req_addr,
    input  logic [NLANE-1:0]          req_uncached,
    output logic [NLANE-1:0]          rsp_valid,
    output logic [2*NLANE-1:0]        rsp_code,
    output logic [NLANE-1:0]          wr_en,
    output logic [NLANE-1:0]          warn_valid,
    output logic [CTX_W*NLANE-1:0]    warn_ctx
);
    localparam int               PER_W    = (WARN_PERIOD > 2) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(WARN_PERIOD - 1);
    localparam logic [FAIL_W-1:0] FAIL_MAX = {FAIL_W{1'b1}};

    typedef struct packed {
        logic [NCTX-1:0]                    flag;
        logic [NCTX-1:0][ADDR_W-1:0]        addr;
        logic [NCTX-1:0][FAIL_W-1:0]        fcnt;
        logic [NCTX-1:0][PER_W-1:0]         per;
        logic                               ready;
        logic [NLANE-1:0]                   rsp_v;
        logic [NLANE-1:0][1:0]              rsp_code;
        logic [NLANE-1:0]                   wr;
        logic [NLANE-1:0]                   warn;
        logic [NLANE-1:0][CTX_W-1:0]        warn_ctx;
    } state_t;

    state_t st_d, st_q;

    logic [NLANE-1:0]              ln_ll, ln_sc, ln_st, ln_unc;
    logic [NLANE-1:0][CTX_W-1:0]   ln_ctx;
    logic [NLANE-1:0][ADDR_W-1:0]  ln_addr;
    logic [NLANE-1:0][NCTX-1:0]    hit;

    // Per-lane decode and lane-by-context block comparators.
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        rsv_lane_unpack #(
            .CTX_W  (CTX_W),
            .ADDR_W (ADDR_W)
        ) u_unpack (
            .valid_i (req_valid[l]),
            .ready_i (st_q.ready),
            .kind_i  (req_kind[2*l +: 2]),
            .ctx_i   (req_ctx[CTX_W*l +: CTX_W]),
            .addr_i  (req_addr[ADDR_W*l +: ADDR_W]),
            .unc_i   (req_uncached[l]),
            .is_ll_o (ln_ll[l]),
            .is_sc_o (ln_sc[l]),
            .is_st_o (ln_st[l]),
            .unc_o   (ln_unc[l]),
            .ctx_o   (ln_ctx[l]),
            .addr_o  (ln_addr[l])
        );
        for (genvar k = 0; k < NCTX; k++) begin : g_ctx
            rsv_blk_cmp #(
                .ADDR_W  (ADDR_W),
                .BLK_LSB (BLK_LSB)
            ) u_cmp (
                .a_i    (st_q.addr[k]),
                .b_i    (ln_addr[l]),
                .same_o (hit[l][k])
            );
        end
    end

    // Next-state: stores in lane order first, then load-linked requests.
    always_comb begin
        logic             do_clr;
        logic [CTX_W-1:0] cx;

        st_d          = st_q;
        st_d.ready    = 1'b1;
        st_d.rsp_v    = '0;
        st_d.rsp_code = '0;
        st_d.wr       = '0;
        st_d.warn     = '0;
        st_d.warn_ctx = '0;
        do_clr        = 1'b0;
        cx            = '0;

        for (int l = 0; l < NLANE; l++) begin
            do_clr = 1'b0;
            cx     = ln_ctx[l];
            if (ln_st[l]) begin
                st_d.rsp_v[l]    = 1'b1;
                st_d.rsp_code[l] = CODE_WR;
                st_d.wr[l]       = 1'b1;
                do_clr           = 1'b1;
            end else if (ln_sc[l] && ln_unc[l]) begin
                st_d.rsp_v[l]    = 1'b1;
                st_d.rsp_code[l] = CODE_UNC;
                st_d.wr[l]       = 1'b1;
                st_d.fcnt[cx]    = '0;
                st_d.per[cx]     = '0;
                do_clr           = 1'b1;
            end else if (ln_sc[l] && st_d.flag[cx] && hit[l][cx]) begin
                st_d.rsp_v[l]    = 1'b1;
                st_d.rsp_code[l] = CODE_PASS;
                st_d.wr[l]       = 1'b1;
                st_d.fcnt[cx]    = '0;
                st_d.per[cx]     = '0;
                do_clr           = 1'b1;
            end else if (ln_sc[l]) begin
                st_d.rsp_v[l]    = 1'b1;
                st_d.rsp_code[l] = CODE_FAIL;
                st_d.flag[cx]    = 1'b0;
                if (st_d.fcnt[cx] != FAIL_MAX) begin
                    st_d.fcnt[cx] = st_d.fcnt[cx] + 1'b1;
                    if (st_d.per[cx] == PER_LAST) begin
                        st_d.per[cx]      = '0;
                        st_d.warn[l]      = 1'b1;
                        st_d.warn_ctx[l]  = cx;
                    end else begin
                        st_d.per[cx] = st_d.per[cx] + 1'b1;
                    end
                end
            end
            if (do_clr) begin
                for (int k = 0; k < NCTX; k++) begin
                    if (hit[l][k]) st_d.flag[k] = 1'b0;
                end
            end
        end

        for (int l = 0; l < NLANE; l++) begin
            if (ln_ll[l]) begin
                cx               = ln_ctx[l];
                st_d.flag[cx]    = 1'b1;
                st_d.addr[cx]    = ln_addr[l];
                st_d.rsp_v[l]    = 1'b1;
                st_d.rsp_code[l] = CODE_PASS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready  = st_q.ready;
    assign rsp_valid  = st_q.rsp_v;
    assign rsp_code   = st_q.rsp_code;
    assign wr_en      = st_q.wr;
    assign warn_valid = st_q.warn;
    assign warn_ctx   = st_q.warn_ctx;

endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
    parameter int NLANE = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NLANE-1:0]   req_valid,
    input logic               req_ready,
    input logic [2*NLANE-1:0] req_kind,
    input logic [NLANE-1:0]   req_uncached,
    input logic [NLANE-1:0]   rsp_valid,
    input logic [2*NLANE-1:0] rsp_code,
    input logic [NLANE-1:0]   wr_en,
    input logic [NLANE-1:0]   warn_valid
);
    always @(negedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (!req_ready && rsp_valid == '0 && warn_valid == '0)
                else $error("reset outputs not idle");
        end
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_chk
        assert_rsp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[l] && req_ready && req_kind[2*l +: 2] != 2'd3) |=> rsp_valid[l]);

        assert_ignored_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (!(req_valid[l] && req_ready) || req_kind[2*l +: 2] == 2'd3) |=> !rsp_valid[l]);

        assert_ll_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[l] && req_ready && req_kind[2*l +: 2] == 2'd0)
            |=> (rsp_code[2*l +: 2] == 2'd1 && !wr_en[l]));

        assert_fail_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid[l] && rsp_code[2*l +: 2] == 2'd0) |-> !wr_en[l]);

        assert_uncached_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[l] && req_ready && req_kind[2*l +: 2] == 2'd1 && req_uncached[l])
            |=> (rsp_code[2*l +: 2] == 2'd2 && wr_en[l]));

        assert_store_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[l] && req_ready && req_kind[2*l +: 2] == 2'd2)
            |=> (rsp_code[2*l +: 2] == 2'd3 && wr_en[l]));

        assert_warn_on_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
            warn_valid[l] |-> (rsp_valid[l] && rsp_code[2*l +: 2] == 2'd0));
    end
endmodule

bind rsv_monitor rsv_monitor_chk #(.NLANE(NLANE)) u_rsv_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_uncached (req_uncached),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .wr_en        (wr_en),
    .warn_valid   (warn_valid)
);

// File: tb/tb_rsv_monitor.sv
module tb_rsv_monitor;
    localparam int NLANE = 2;
    localparam int NCTX  = 4;
    localparam int CW    = 2;
    localparam int AW    = 32;
    localparam int FW    = 4;
    localparam int FMAX  = 15;
    localparam int WP    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NLANE-1:0]    req_valid = '0;
    logic                req_ready;
    logic [2*NLANE-1:0]  req_kind = '0;
    logic [CW*NLANE-1:0] req_ctx = '0;
    logic [AW*NLANE-1:0] req_addr = '0;
    logic [NLANE-1:0]    req_uncached = '0;
    logic [NLANE-1:0]    rsp_valid;
    logic [2*NLANE-1:0]  rsp_code;
    logic [NLANE-1:0]    wr_en;
    logic [NLANE-1:0]    warn_valid;
    logic [CW*NLANE-1:0] warn_ctx;

    rsv_monitor #(
        .NLANE(NLANE), .NCTX(NCTX), .ADDR_W(AW), .BLK_LSB(4),
        .FAIL_W(FW), .WARN_PERIOD(WP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_ctx(req_ctx), .req_addr(req_addr),
        .req_uncached(req_uncached), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .wr_en(wr_en), .warn_valid(warn_valid), .warn_ctx(warn_ctx)
    );

    typedef struct { bit v; int kind; int ctx; int addr; bit unc; } op_t;
    typedef struct {
        bit [1:0] v; bit [1:0] wr; bit [1:0] warn;
        bit [3:0] code; bit [3:0] wctx; string tag;
    } exp_t;

    exp_t q[$];
    bit   mflag[NCTX];
    int   maddr[NCTX];
    int   mcnt[NCTX];
    int   mper[NCTX];
    int   errors = 0;
    int   checks = 0;
    bit   ended  = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic op_t mk(int kind, int ctx, int addr, bit unc = 1'b0);
        op_t o;
        o.v = 1'b1; o.kind = kind; o.ctx = ctx; o.addr = addr; o.unc = unc;
        return o;
    endfunction

    function automatic op_t idle();
        op_t o;
        o.v = 1'b0; o.kind = 0; o.ctx = 0; o.addr = 0; o.unc = 1'b0;
        return o;
    endfunction

    // Driver: drives one cycle and pushes the expected outcome.
    task automatic step(op_t o0, op_t o1, string tag);
        op_t  ops[2];
        exp_t e;
        ops[0] = o0; ops[1] = o1;
        e.v = '0; e.wr = '0; e.warn = '0; e.code = '0; e.wctx = '0; e.tag = tag;
        @(negedge clk);
        for (int l = 0; l < NLANE; l++) begin
            req_valid[l]          = ops[l].v;
            req_kind[2*l +: 2]    = ops[l].kind[1:0];
            req_ctx[CW*l +: CW]   = ops[l].ctx[CW-1:0];
            req_addr[AW*l +: AW]  = ops[l].addr;
            req_uncached[l]       = ops[l].unc;
        end
        // Stores and store-conditionals first, lane order (R11).
        for (int l = 0; l < NLANE; l++) begin
            int  c; bit clr;
            c = ops[l].ctx; clr = 1'b0;
            if (ops[l].v && ops[l].kind == 2) begin
                e.v[l] = 1; e.code[2*l +: 2] = 3; e.wr[l] = 1; clr = 1;
            end else if (ops[l].v && ops[l].kind == 1 && ops[l].unc) begin
                e.v[l] = 1; e.code[2*l +: 2] = 2; e.wr[l] = 1; clr = 1;
                mcnt[c] = 0; mper[c] = 0;
            end else if (ops[l].v && ops[l].kind == 1) begin
                e.v[l] = 1;
                if (mflag[c] && (maddr[c] >>> 4) == (ops[l].addr >>> 4)) begin
                    e.code[2*l +: 2] = 1; e.wr[l] = 1; clr = 1;
                    mcnt[c] = 0; mper[c] = 0;
                end else begin
                    e.code[2*l +: 2] = 0; mflag[c] = 0;
                    if (mcnt[c] < FMAX) begin
                        mcnt[c]++;
                        if (mcnt[c] % WP == 0) begin
                            e.warn[l] = 1; e.wctx[2*l +: 2] = c[1:0];
                        end
                    end
                end
            end
            if (clr)
                for (int k = 0; k < NCTX; k++)
                    if ((maddr[k] >>> 4) == (ops[l].addr >>> 4)) mflag[k] = 0;
        end
        for (int l = 0; l < NLANE; l++) begin
            if (ops[l].v && ops[l].kind == 0) begin
                mflag[ops[l].ctx] = 1; maddr[ops[l].ctx] = ops[l].addr;
                e.v[l] = 1; e.code[2*l +: 2] = 1;
            end
        end
        q.push_back(e);
    endtask

    task automatic one(op_t o, string tag);
        step(o, idle(), tag);
    endtask

    // Monitor: one expectation per cycle, sampled after the edge (R10).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int l = 0; l < NLANE; l++) begin
                    chk(rsp_valid[l] == e.v[l], e.tag, "rsp_valid R10", int'(rsp_valid[l]), int'(e.v[l]));
                    if (e.v[l]) begin
                        chk(rsp_code[2*l +: 2] == e.code[2*l +: 2], e.tag, "rsp_code",
                            int'(rsp_code[2*l +: 2]), int'(e.code[2*l +: 2]));
                        chk(wr_en[l] == e.wr[l], e.tag, "wr_en", int'(wr_en[l]), int'(e.wr[l]));
                    end
                    chk(warn_valid[l] == e.warn[l], e.tag, "warn_valid", int'(warn_valid[l]), int'(e.warn[l]));
                    if (e.warn[l])
                        chk(warn_ctx[CW*l +: CW] == e.wctx[2*l +: 2], e.tag, "warn_ctx",
                            int'(warn_ctx[CW*l +: CW]), int'(e.wctx[2*l +: 2]));
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        for (int k = 0; k < NCTX; k++) begin
            mflag[k] = 0; maddr[k] = 0; mcnt[k] = 0; mper[k] = 0;
        end
        repeat (3) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R1", "ready in reset", int'(req_ready), 0);
            chk(rsp_valid == '0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);

        // R1: no reservation after reset.
        one(mk(1, 0, 'h0), "R1");
        // R2 / R3: link then pass in same block.
        one(mk(0, 0, 'h100), "R2");
        one(mk(1, 0, 'h10C), "R3");
        // R3 / R4: other block fails, then flag is gone.
        one(mk(0, 1, 'h200), "R2");
        one(mk(1, 1, 'h210), "R3");
        one(mk(1, 1, 'h200), "R4");
        // R6: plain store clears two other contexts.
        one(mk(0, 0, 'h300), "R2");
        one(mk(0, 1, 'h308), "R2");
        one(mk(0, 2, 'h400), "R2");
        one(mk(2, 3, 'h30F), "R6");
        one(mk(1, 2, 'h400), "R6");
        one(mk(1, 0, 'h300), "R6");
        one(mk(1, 1, 'h308), "R6");
        // R6: issuer's own store clears its reservation.
        one(mk(0, 0, 'h500), "R2");
        one(mk(2, 0, 'h500), "R6");
        one(mk(1, 0, 'h500), "R6");
        // R7: failed SC does not invalidate others; pass does.
        one(mk(0, 1, 'h600), "R2");
        one(mk(0, 2, 'h600), "R2");
        one(mk(1, 3, 'h600), "R7");
        one(mk(1, 1, 'h600), "R7");
        one(mk(1, 2, 'h600), "R6");
        // R5: uncached SC without reservation, and it invalidates.
        one(mk(1, 0, 'h0, 1'b1), "R5");
        one(mk(0, 1, 'h800), "R2");
        one(mk(1, 0, 'h800, 1'b1), "R5");
        one(mk(1, 1, 'h800), "R5");
        // R11: LL on lane 0 and store to same block on lane 1.
        step(mk(0, 0, 'h900), mk(2, 1, 'h900), "R11");
        one(mk(1, 0, 'h900), "R11");
        // R11: two SCs to one block in one cycle, lower lane wins.
        one(mk(0, 0, 'hA00), "R2");
        one(mk(0, 1, 'hA04), "R2");
        step(mk(1, 1, 'hA00), mk(1, 0, 'hA00), "R11");
        // R11: both lanes fail for one context in one cycle.
        step(mk(1, 1, 'hB00), mk(1, 1, 'hB00), "R4");
        // R12: kind 3 ignored, reservation survives.
        one(mk(0, 0, 'hC00), "R2");
        one(mk(3, 0, 'hC00), "R12");
        step(mk(3, 1, 'hC00), mk(3, 2, 'hC00), "R12");
        one(mk(1, 0, 'hC00), "R12");
        // R9 / R8: reset count with pass, then streak with warnings.
        one(mk(0, 3, 'hD00), "R2");
        one(mk(1, 3, 'hD00), "R9");
        for (int i = 0; i < 5; i++) one(mk(1, 3, 'hE00), "R8");
        for (int i = 0; i < 25; i++) one(mk(1, 3, 'hE00), "R9");
        // R5: uncached SC resets the streak count.
        for (int i = 0; i < 3; i++) one(mk(1, 2, 'hF00), "R4");
        one(mk(1, 2, 'hF00, 1'b1), "R5");
        for (int i = 0; i < 6; i++) one(mk(1, 2, 'hF00), "R8");
        // R8: warning from lane 1.
        for (int i = 0; i < 5; i++) step(idle(), mk(1, 1, 'h1000), "R8");
        repeat (3) one(idle(), "R10");
        @(negedge clk);
        req_valid = '0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule